// File: doc/BRIEF.md
# Frame Border ROI Trimmer

This block sits after an unpadded neighborhood filter. Such a filter leaves a band of meaningless pixels around the edge of every frame. The block takes that pixel stream, together with its frame and line markers, and drops the band. It removes floor(KERN_H/2) lines at the top and at the bottom of each frame, and floor(KERN_W/2) pixels at the left and at the right of each line. Pixel data is not altered.

The markers are rebuilt for the cropped window, so the stream leaving the block is a well-formed smaller frame. Line start and line end mark the first and last kept pixel of each kept line. Frame start and frame end mark the first and last kept pixel of the frame. Data and markers leave the block exactly one clock after they arrive.

Position is tracked with a column counter and a row counter. They move only on valid pixels, so idle cycles inside a line do not disturb the crop. Pixels that fall outside a line (after its end and before the next line start) are dropped. Pixels that fall outside a frame (after its end and before the next frame start) are dropped as well.

Top module: `frame_border_trim`

## Requirements
- R1: For an input line with index r (the line carrying the frame start is r=0), no output pixel is valid unless LR <= r <= FRAME_H-1-LR, where LR = floor(KERN_H/2).
- R2: For an input pixel with column c (the pixel carrying line start is c=0), no output pixel is valid unless LC <= c <= FRAME_W-1-LC, where LC = floor(KERN_W/2).
- R3: Every kept input pixel appears on data_o with valid_o high exactly one clock later, with its data unchanged. A frame therefore yields (FRAME_W-2*LC)*(FRAME_H-2*LR) valid output pixels.
- R4: hstart_o is high together with the output pixel from column LC of each kept line, and hend_o together with the one from column FRAME_W-1-LC. Neither is high at any other time.
- R5: vstart_o is high only together with hstart_o on line LR. vend_o is high only together with hend_o on line FRAME_H-1-LR.
- R6: A cycle with valid_i low gives all output controls low one clock later. It also does not advance the column or row position.
- R7: A valid pixel carrying vstart_i restarts the position at row 0, column 0, even in the middle of a frame. A valid pixel carrying hstart_i sets the column to 0 and moves to the next row.
- R8: While rst_ni is low, every output control is low.
- R9: With the default parameters (320x240 input, 15x15 kernel), one frame yields 69156 valid pixels, 226 line starts, 226 line ends, one frame start and one frame end.
- R10: A valid pixel that arrives after hend_i and before the next hstart_i is not emitted. Neither is one that arrives after vend_i and before the next vstart_i.

All controls are active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | PIX_W | Input pixel |
| valid_i | input | 1 | Input pixel valid |
| hstart_i | input | 1 | First pixel of an input line |
| hend_i | input | 1 | Last pixel of an input line |
| vstart_i | input | 1 | First pixel of an input frame |
| vend_i | input | 1 | Last pixel of an input frame |
| data_o | output | PIX_W | Output pixel, one clock after input |
| valid_o | output | 1 | Output pixel valid (kept pixel) |
| hstart_o | output | 1 | First kept pixel of a kept line |
| hend_o | output | 1 | Last kept pixel of a kept line |
| vstart_o | output | 1 | First kept pixel of the frame |
| vend_o | output | 1 | Last kept pixel of the frame |

## Verification
Two coincidences matter most here. The first: the last kept pixel of the last kept line must raise line end and frame end in the same cycle, and the first kept pixel must raise line start and frame start in the same cycle. Full frames with and without idle gaps provoke both, and every output cycle is compared with the expected marker set for its row and column. The second: a frame start can arrive while the counters sit mid-frame, so the row restart and the line start land in one cycle. An aborted partial frame followed by a full one provokes it, and the crop of the new frame is judged pixel by pixel.

// File: rtl/brt_pkg.sv
package brt_pkg;
  typedef struct packed {
    logic vld;
    logic hs;
    logic he;
    logic vs;
    logic ve;
  } ctl_t;
endpackage

// File: rtl/brt_pos_track.sv
module brt_pos_track #(
  parameter int W = 320,
  parameter int H = 240
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic                       hstart_i,
  input  logic                       hend_i,
  input  logic                       vstart_i,
  input  logic                       vend_i,
  output logic [$clog2(W+1)-1:0]     cur_col_o,
  output logic [$clog2(H+1)-1:0]     cur_row_o,
  output logic                       live_o
);
  localparam int CW = $clog2(W+1);
  localparam int RW = $clog2(H+1);
  localparam logic [CW-1:0] COL_MAX = CW'(W);
  localparam logic [RW-1:0] ROW_MAX = RW'(H);

  logic [CW-1:0] col_q, col_c;
  logic [RW-1:0] row_q, row_c;
  logic          line_q, frame_q, line_c, frame_c;

  always_comb begin
    col_c   = hstart_i ? '0 : col_q;
    if (vstart_i)                         row_c = '0;
    else if (hstart_i && row_q != ROW_MAX) row_c = row_q + RW'(1);
    else                                  row_c = row_q;
    line_c  = hstart_i | line_q;
    frame_c = vstart_i | frame_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q   <= '0;
      row_q   <= '0;
      line_q  <= 1'b0;
      frame_q <= 1'b0;
    end else if (valid_i) begin
      col_q   <= (col_c == COL_MAX) ? col_c : col_c + CW'(1);
      row_q   <= row_c;
      line_q  <= line_c & ~hend_i;
      frame_q <= frame_c & ~vend_i;
    end
  end

  assign cur_col_o = col_c;
  assign cur_row_o = row_c;
  assign live_o    = valid_i & line_c & frame_c;

  // R7
  row_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && vstart_i) |=> (row_q == '0 && frame_q == !$past(vend_i)));

  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(col_q) && $stable(row_q)));

  // R2
  col_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_q <= COL_MAX);
endmodule

// File: rtl/brt_window.sv
module brt_window
  import brt_pkg::*;
#(
  parameter int W  = 320,
  parameter int H  = 240,
  parameter int LC = 7,
  parameter int LR = 7
) (
  input  logic [$clog2(W+1)-1:0] cur_col_i,
  input  logic [$clog2(H+1)-1:0] cur_row_i,
  input  logic                   live_i,
  output ctl_t                   ctl_o
);
  localparam int CW = $clog2(W+1);
  localparam int RW = $clog2(H+1);
  localparam logic [CW-1:0] COL_LO = CW'(LC);
  localparam logic [CW-1:0] COL_HI = CW'(W - 1 - LC);
  localparam logic [RW-1:0] ROW_LO = RW'(LR);
  localparam logic [RW-1:0] ROW_HI = RW'(H - 1 - LR);

  logic col_lo_ok, row_lo_ok, col_ok, row_ok;

  // zero trim leaves no lower bound to compare against
  if (LC == 0) begin : g_col_nolo
    assign col_lo_ok = 1'b1;
  end else begin : g_col_lo
    assign col_lo_ok = (cur_col_i >= COL_LO);
  end

  if (LR == 0) begin : g_row_nolo
    assign row_lo_ok = 1'b1;
  end else begin : g_row_lo
    assign row_lo_ok = (cur_row_i >= ROW_LO);
  end

  assign col_ok = col_lo_ok & (cur_col_i <= COL_HI);
  assign row_ok = row_lo_ok & (cur_row_i <= ROW_HI);

  always_comb begin
    ctl_o.vld = live_i & col_ok & row_ok;
    ctl_o.hs  = ctl_o.vld & (cur_col_i == COL_LO);
    ctl_o.he  = ctl_o.vld & (cur_col_i == COL_HI);
    ctl_o.vs  = ctl_o.hs  & (cur_row_i == ROW_LO);
    ctl_o.ve  = ctl_o.he  & (cur_row_i == ROW_HI);
  end
endmodule

// File: rtl/brt_out_reg.sv
module brt_out_reg
  import brt_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIX_W-1:0] data_i,
  input  ctl_t             ctl_i,
  output logic [PIX_W-1:0] data_o,
  output ctl_t             ctl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      ctl_o  <= '0;
    end else begin
      data_o <= data_i;
      ctl_o  <= ctl_i;
    end
  end

  // R5
  vs_with_hs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_o.vs |-> ctl_o.hs);

  // R5
  ve_with_he_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_o.ve |-> ctl_o.he);

  // R4
  marks_need_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_o.hs || ctl_o.he) |-> ctl_o.vld);
endmodule

// File: rtl/frame_border_trim.sv
module frame_border_trim
  import brt_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int FRAME_W = 320,
  parameter int FRAME_H = 240,
  parameter int KERN_W  = 15,
  parameter int KERN_H  = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIX_W-1:0] data_i,
  input  logic             valid_i,
  input  logic             hstart_i,
  input  logic             hend_i,
  input  logic             vstart_i,
  input  logic             vend_i,
  output logic [PIX_W-1:0] data_o,
  output logic             valid_o,
  output logic             hstart_o,
  output logic             hend_o,
  output logic             vstart_o,
  output logic             vend_o
);
  localparam int TRIM_C = KERN_W / 2;
  localparam int TRIM_R = KERN_H / 2;
  localparam int CW     = $clog2(FRAME_W + 1);
  localparam int RW     = $clog2(FRAME_H + 1);

  logic [CW-1:0] cur_col;
  logic [RW-1:0] cur_row;
  logic          live;
  ctl_t          ctl_nxt, ctl_q;

  brt_pos_track #(.W(FRAME_W), .H(FRAME_H)) u_pos (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .hstart_i  (hstart_i),
    .hend_i    (hend_i),
    .vstart_i  (vstart_i),
    .vend_i    (vend_i),
    .cur_col_o (cur_col),
    .cur_row_o (cur_row),
    .live_o    (live)
  );

  brt_window #(.W(FRAME_W), .H(FRAME_H), .LC(TRIM_C), .LR(TRIM_R)) u_win (
    .cur_col_i (cur_col),
    .cur_row_i (cur_row),
    .live_i    (live),
    .ctl_o     (ctl_nxt)
  );

  brt_out_reg #(.PIX_W(PIX_W)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (data_i),
    .ctl_i  (ctl_nxt),
    .data_o (data_o),
    .ctl_o  (ctl_q)
  );

  assign valid_o  = ctl_q.vld;
  assign hstart_o = ctl_q.hs;
  assign hend_o   = ctl_q.he;
  assign vstart_o = ctl_q.vs;
  assign vend_o   = ctl_q.ve;

  // R3
  valid_from_input_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i));

  // R6
  idle_no_output_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !(valid_o || hstart_o || hend_o || vstart_o || vend_o));

  // R3
  data_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (data_o == $past(data_i)));
endmodule

// File: tb/frame_border_trim_bench.sv
module frame_border_trim_bench;
  localparam int BW  = 16;
  localparam int BH  = 12;
  localparam int BKW = 5;
  localparam int BKH = 3;
  localparam int BLC = BKW / 2;
  localparam int BLR = BKH / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int errors = 0;
  int checks = 0;

  logic [7:0] d_i = '0;
  logic v_i = 0, hs_i = 0, he_i = 0, vs_i = 0, ve_i = 0;
  logic [7:0] d_o;
  logic v_o, hs_o, he_o, vs_o, ve_o;

  frame_border_trim #(.PIX_W(8), .FRAME_W(BW), .FRAME_H(BH),
                      .KERN_W(BKW), .KERN_H(BKH)) u_frame_border_trim (
    .clk_i(clk), .rst_ni(rst_n), .data_i(d_i), .valid_i(v_i),
    .hstart_i(hs_i), .hend_i(he_i), .vstart_i(vs_i), .vend_i(ve_i),
    .data_o(d_o), .valid_o(v_o), .hstart_o(hs_o), .hend_o(he_o),
    .vstart_o(vs_o), .vend_o(ve_o)
  );

  logic [7:0] fd_i = '0;
  logic fv_i = 0, fhs_i = 0, fhe_i = 0, fvs_i = 0, fve_i = 0;
  logic [7:0] fd_o;
  logic fv_o, fhs_o, fhe_o, fvs_o, fve_o;

  frame_border_trim u_frame_border_trim_full (
    .clk_i(clk), .rst_ni(rst_n), .data_i(fd_i), .valid_i(fv_i),
    .hstart_i(fhs_i), .hend_i(fhe_i), .vstart_i(fvs_i), .vend_i(fve_i),
    .data_o(fd_o), .valid_o(fv_o), .hstart_o(fhs_o), .hend_o(fhe_o),
    .vstart_o(fvs_o), .vend_o(fve_o)
  );

  int n_v, n_hs, n_he, n_vs, n_ve;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp,
                     input logic [7:0] dact, input logic [7:0] dexp, input bit use_d);
    checks++;
    if (act !== exp || (use_d && dact !== dexp)) begin
      errors++;
      $display("FAIL %s ctl act=%b exp=%b data act=%0d exp=%0d", tag, act, exp, dact, dexp);
    end
  endtask

  // after the posedge that captured pixel (r,c); live = pixel inside line and frame
  task automatic check_px(input string tag, input int r, input int c, input bit live);
    bit kv, ehs, ehe;
    kv  = live && r >= BLR && r <= BH-1-BLR && c >= BLC && c <= BW-1-BLC;
    ehs = kv && c == BLC;
    ehe = kv && c == BW-1-BLC;
    chk(tag, {v_o, hs_o, he_o, vs_o, ve_o},
        {kv, ehs, ehe, ehs && r == BLR, ehe && r == BH-1-BLR}, d_o, 8'(r*BW+c), kv);
    n_v += int'(v_o); n_hs += int'(hs_o); n_he += int'(he_o);
    n_vs += int'(vs_o); n_ve += int'(ve_o);
  endtask

  task automatic drive_px(input string tag, input int r, input int c,
                          input bit marks, input bit live, input bit gap);
    d_i  = 8'(r*BW+c);
    v_i  = 1;
    hs_i = marks && c == 0;
    he_i = marks && c == BW-1;
    vs_i = marks && c == 0 && r == 0;
    ve_i = marks && c == BW-1 && r == BH-1;
    @(negedge clk);
    check_px(tag, r, c, live);
    {v_i, hs_i, he_i, vs_i, ve_i} = '0;
    d_i = 8'hA5;
    if (gap) begin
      @(negedge clk);
      chk("R6 idle", {v_o, hs_o, he_o, vs_o, ve_o}, 5'b0, d_o, 8'h0, 0);
    end
  endtask

  task automatic frame_counts(input string tag);
    chk({tag, " R3 valid count"}, 5'(n_v == (BW-2*BLC)*(BH-2*BLR)), 5'd1, 0, 0, 0);
    chk({tag, " R4 line marks"}, {3'b0, n_hs == BH-2*BLR, n_he == BH-2*BLR}, 5'b11, 0, 0, 0);
    chk({tag, " R5 frame marks"}, {3'b0, n_vs == 1, n_ve == 1}, 5'b11, 0, 0, 0);
  endtask

  task automatic run_frame(input string tag, input bit gaps);
    n_v = 0; n_hs = 0; n_he = 0; n_vs = 0; n_ve = 0;
    for (int r = 0; r < BH; r++)
      for (int c = 0; c < BW; c++)
        drive_px(tag, r, c, 1, 1, gaps && ((r*7 + c) % 3 == 0));
    frame_counts(tag);
  endtask

  task automatic test_reset();
    v_i = 1; hs_i = 1; vs_i = 1; d_i = 8'h11;
    repeat (3) @(negedge clk);
    chk("R8 reset", {v_o, hs_o, he_o, vs_o, ve_o}, 5'b0, d_o, 8'h0, 0);
    chk("R8 reset full", {fv_o, fhs_o, fhe_o, fvs_o, fve_o}, 5'b0, fd_o, 8'h0, 0);
    {v_i, hs_i, vs_i} = '0;
    rst_n = 1;
    @(negedge clk);
    chk("R8 after release", {v_o, hs_o, he_o, vs_o, ve_o}, 5'b0, d_o, 8'h0, 0);
  endtask

  task automatic test_abort();
    for (int r = 0; r < 5; r++)
      for (int c = 0; c < BW; c++)
        drive_px("R7 partial", r, c, 1, 1, 0);
    run_frame("R7 restart", 0);
  endtask

  task automatic test_stray();
    n_v = 0; n_hs = 0; n_he = 0; n_vs = 0; n_ve = 0;
    for (int r = 0; r < BH; r++) begin
      for (int c = 0; c < BW; c++)
        drive_px("R1 R2 R4 R5 stray frame", r, c, 1, 1, 0);
      if (r == 3) begin
        drive_px("R10 after line end", r, 5, 0, 0, 0);
        drive_px("R10 after line end", r, 8, 0, 0, 1);
      end
    end
    frame_counts("R10");
    for (int k = 0; k < 4; k++)
      drive_px("R10 after frame end", 2, BLC + k, 0, 0, 0);
  endtask

  task automatic test_default();
    int cv = 0, chs = 0, che = 0, cvs = 0, cve = 0;
    for (int r = 0; r < 240; r++)
      for (int c = 0; c < 320; c++) begin
        fd_i  = 8'(c);
        fv_i  = 1;
        fhs_i = c == 0;
        fhe_i = c == 319;
        fvs_i = c == 0 && r == 0;
        fve_i = c == 319 && r == 239;
        @(negedge clk);
        cv += int'(fv_o); chs += int'(fhs_o); che += int'(fhe_o);
        cvs += int'(fvs_o); cve += int'(fve_o);
        if (fhs_o) chk("R9 first kept column", 5'd0, 5'd0, fd_o, 8'd7, 1);
      end
    {fv_i, fhs_i, fhe_i, fvs_i, fve_i} = '0;
    @(negedge clk);
    chk("R9 pixel count", 5'(cv == 69156), 5'd1, 0, 0, 0);
    chk("R9 line marks", {3'b0, chs == 226, che == 226}, 5'b11, 0, 0, 0);
    chk("R9 frame marks", {3'b0, cvs == 1, cve == 1}, 5'b11, 0, 0, 0);
  endtask

  initial begin
    #(10 * 190000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    @(negedge clk);
    test_reset();
    run_frame("R1 R2 R3 R4 R5 plain", 0);
    run_frame("R6 gapped", 1);
    test_abort();
    test_stray();
    test_default();
    summary();
  end
endmodule